// File: doc/BRIEF.md
# System Clock Source Switch Controller

This block decides which of four oscillator sources feeds the system clock: a multi-speed internal oscillator, a 16 MHz internal oscillator, an external oscillator and a PLL output. Software posts a requested source through a small register port. The block watches one ready line per source and moves the active selection only when the requested source is ready. A request for a source that is not yet ready is held. It completes by itself as soon as that source reports ready.

The block also owns the oscillator enable bits. A write that would switch off the source in use is overridden, so the active source keeps running. When the PLL is the active source, the oscillator that feeds the PLL is also kept running. The PLL's input selection is frozen while the PLL is active. The active source code drives an external glitch-free clock multiplexer. The analog parts, the PLL and that multiplexer are outside this block.

Top module: `sysclk_sel_ctrl`

## Requirements
- R1: Source codes are 00 = multi-speed internal, 01 = 16 MHz internal, 10 = external, 11 = PLL. In `osc_en` and in the ready fields, bit i belongs to code i. After reset:
  - the active source is 00;
  - no switch is pending;
  - `osc_en` = 0001;
  - `pll_from_ext` = 0.
- R2: Each `rdy_raw` bit passes through a two-flop synchroniser before use. When a switch is pending and the target's raw ready rises, `sys_src` changes on the third rising clock edge after the rise, and not before.
- R3: A request for a source whose synchronised ready is low leaves `sys_src` unchanged and sets the pending flag. `sys_src` only ever takes a value whose synchronised ready was high in the previous cycle.
- R4: A pending switch completes on its own. When the target's synchronised ready is already high, the switch lands on the clock edge after the edge that took the request, and the pending flag clears.
- R5: A new request replaces the pending target. A request equal to the active source clears the pending flag. A request takes priority over a completion in the same cycle.
- R6: A write to the enable register that clears the bit of the active source is ignored for that bit only. The other bits take the written value.
- R7: While the PLL is active:
  - a write that clears the enable of the PLL's input oscillator is ignored for that bit;
  - a write to the PLL input select bit is ignored.

  The PLL input select bit is 0 for the 16 MHz internal oscillator and 1 for the external one. It is writable again once the PLL is no longer active.
- R8: While the pending target's synchronised ready stays low, `sys_src` does not change and the pending flag stays set, however long that lasts.
- R9: Register map:

  | Address | Written fields | Read value |
  |---|---|---|
  | 0 | enables in bits [3:0], PLL input select in bit [4] | same layout |
  | 1 | requested source in bits [1:0] | bits [1:0] active source, bits [3:2] last requested target, bit [4] pending |
  | 2 | none | synchronised ready in bits [3:0], bit [4] reads 0 |
  | 3 | none | reads 0 |

  Reads are combinational from `reg_addr` when `wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for writes and reads |
| wr_data | input | 5 | Write data |
| rdy_raw | input | 4 | Asynchronous ready lines, one per source code |
| rd_data | output | 5 | Read data for `reg_addr` |
| osc_en | output | 4 | Oscillator enables, one per source code |
| pll_from_ext | output | 1 | PLL input select: 1 = external, 0 = 16 MHz internal |
| sys_src | output | 2 | Active system clock source code |

## Verification
Suppose the pending flag or the stored target is corrupted. Then `sys_src` either moves to a source that was never ready or fails to move. This shows at the port on the third edge after the raw ready rises, or on the edge after a request when the ready is already synchronised. Suppose the protection mask tracks the wrong source. Then `osc_en` drops the running oscillator, or the PLL input, on the edge after the offending write. The address 1 and address 2 reads expose the pending state and the synchronised ready lines directly, so a stuck state is visible one read after it occurs.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

    localparam int NSRC   = 4;
    localparam int SEL_W  = 2;
    localparam int DATA_W = NSRC + 1;
    localparam int ADDR_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_MULTI = 2'b00,
        SRC_INT16 = 2'b01,
        SRC_EXT   = 2'b10,
        SRC_PLL   = 2'b11
    } src_e;

    localparam logic [ADDR_W-1:0] A_ENABLE = 2'd0;
    localparam logic [ADDR_W-1:0] A_SELECT = 2'd1;
    localparam logic [ADDR_W-1:0] A_READY  = 2'd2;

    typedef struct packed {
        logic pending;
        src_e target;
        src_e active;
    } sw_state_t;

    // Oscillators that must stay on for a given active source
    function automatic logic [NSRC-1:0] keep_mask(src_e act, logic pll_ext);
        logic [NSRC-1:0] m;
        m = NSRC'(1) << act;
        if (act == SRC_PLL)
            m = m | (pll_ext ? (NSRC'(1) << SRC_EXT) : (NSRC'(1) << SRC_INT16));
        return m;
    endfunction

endpackage

// File: rtl/sysclk_rdy_sync.sv
module sysclk_rdy_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], din[i]};
        end
        assign dout[i] = chain[STAGES-1];
    end
endmodule

// File: rtl/sysclk_switch_fsm.sv
module sysclk_switch_fsm
    import sysclk_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  src_e            req_src,
    input  logic [NSRC-1:0] rdy_s,
    output sw_state_t       st
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st.pending <= 1'b0;
            st.target  <= SRC_MULTI;
            st.active  <= SRC_MULTI;
        end else if (req_valid) begin
            st.target  <= req_src;
            st.pending <= (req_src != st.active);
        end else if (st.pending && rdy_s[st.target]) begin
            st.active  <= st.target;
            st.pending <= 1'b0;
        end
    end
endmodule

// File: rtl/sysclk_osc_guard.sv
module sysclk_osc_guard
    import sysclk_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic [NSRC:0]   wdata,
    input  src_e            active,
    output logic [NSRC-1:0] en,
    output logic            pll_ext
);
    logic [NSRC-1:0] en_q;
    logic            pll_q;
    logic [NSRC-1:0] keep;

    assign keep = keep_mask(active, pll_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= NSRC'(1) << SRC_MULTI;
            pll_q <= 1'b0;
        end else if (wr) begin
            en_q <= wdata[NSRC-1:0] | keep;
            if (active != SRC_PLL) pll_q <= wdata[NSRC];
        end else begin
            en_q <= en_q | keep;
        end
    end

    // keep covers the cycle between a switch landing and en_q catching up
    assign en      = en_q | keep;
    assign pll_ext = pll_q;
endmodule

// File: rtl/sysclk_sel_ctrl.sv
module sysclk_sel_ctrl
    import sysclk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NSRC-1:0]   rdy_raw,
    output logic [DATA_W-1:0] rd_data,
    output logic [NSRC-1:0]   osc_en,
    output logic              pll_from_ext,
    output logic [SEL_W-1:0]  sys_src
);
    logic [NSRC-1:0] rdy_s;
    sw_state_t       st;
    logic            wr_enable;
    logic            wr_select;

    assign wr_enable = wr_en && (reg_addr == A_ENABLE);
    assign wr_select = wr_en && (reg_addr == A_SELECT);

    sysclk_rdy_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (rdy_raw),
        .dout(rdy_s)
    );

    sysclk_switch_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req_valid(wr_select),
        .req_src  (src_e'(wr_data[SEL_W-1:0])),
        .rdy_s    (rdy_s),
        .st       (st)
    );

    sysclk_osc_guard u_guard (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr_enable),
        .wdata  (wr_data),
        .active (st.active),
        .en     (osc_en),
        .pll_ext(pll_from_ext)
    );

    assign sys_src = st.active;

    always_comb begin
        case (reg_addr)
            A_ENABLE: rd_data = {pll_from_ext, osc_en};
            A_SELECT: rd_data = {st.pending, st.target, st.active};
            A_READY:  rd_data = {1'b0, rdy_s};
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/sysclk_sel_ctrl_chk.sv
module sysclk_sel_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [1:0] reg_addr,
    input logic [4:0] wr_data,
    input logic [3:0] osc_en,
    input logic       pll_from_ext,
    input logic [1:0] sys_src,
    input logic [3:0] rdy_s,
    input logic       pending,
    input logic [1:0] target
);
    logic [3:0] rdy_prev;
    always_ff @(posedge clk) begin
        if (rst) rdy_prev <= '0;
        else     rdy_prev <= rdy_s;
    end

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sys_src == 2'b00 && !pending));

    a_r3_ready_before_move: assert property (@(posedge clk) disable iff (rst)
        !$stable(sys_src) |-> rdy_prev[sys_src]);

    a_r4_auto_complete: assert property (@(posedge clk) disable iff (rst)
        (pending && rdy_s[target] && !(wr_en && reg_addr == 2'd1))
        |=> (sys_src == $past(target) && !pending));

    a_r5_replace_pending: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_addr == 2'd1)
        |=> (target == $past(wr_data[1:0]) && pending == ($past(wr_data[1:0]) != $past(sys_src))));

    a_r6_active_kept_on: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_addr == 2'd0) |=> osc_en[$past(sys_src)]);

    a_r7_pll_input_kept: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_addr == 2'd0 && sys_src == 2'b11 && sys_src == $past(sys_src))
        |=> ($stable(pll_from_ext) && osc_en[pll_from_ext ? 2 : 1]));

    a_r8_hold_while_not_ready: assert property (@(posedge clk) disable iff (rst)
        (pending && !rdy_s[target] && !(wr_en && reg_addr == 2'd1)) |=> ($stable(sys_src) && pending));
endmodule

bind sysclk_sel_ctrl sysclk_sel_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .reg_addr    (reg_addr),
    .wr_data     (wr_data),
    .osc_en      (osc_en),
    .pll_from_ext(pll_from_ext),
    .sys_src     (sys_src),
    .rdy_s       (rdy_s),
    .pending     (st.pending),
    .target      (st.target)
);

// File: tb/sysclk_sel_ctrl_test.sv
module sysclk_sel_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [4:0] wr_data = '0;
    logic [3:0] rdy_raw = '0;
    logic [4:0] rd_data;
    logic [3:0] osc_en;
    logic       pll_from_ext;
    logic [1:0] sys_src;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysclk_sel_ctrl uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .rdy_raw(rdy_raw), .rd_data(rd_data),
        .osc_en(osc_en), .pll_from_ext(pll_from_ext), .sys_src(sys_src)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [4:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [4:0] v);
        reg_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wait_neg(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [4:0] v;
        check("R1 sys_src", sys_src, 0);
        check("R1 osc_en", osc_en, 4'b0001);
        check("R1 pll_from_ext", pll_from_ext, 0);
        rd(2'd0, v); check("R9 enable reg after reset", v, 5'h01);
        rd(2'd1, v); check("R1 select reg after reset", v, 5'h00);
        rd(2'd3, v); check("R9 unused address", v, 5'h00);
    endtask

    task automatic t_pending_then_ready();
        logic [4:0] v;
        wr(2'd0, 5'h03);
        wr(2'd1, 5'h01);
        wait_neg(4);
        check("R3 no move while not ready", sys_src, 0);
        rd(2'd1, v); check("R3 pending shown", v, 5'h14);
        rdy_raw[1] = 1'b1;
        wait_neg(2);
        check("R2 not before third edge", sys_src, 0);
        wait_neg(1);
        check("R2 moved on third edge", sys_src, 1);
        rd(2'd1, v); check("R4 pending cleared", v, 5'h05);
    endtask

    task automatic t_protect_active();
        wr(2'd0, 5'h01);
        check("R6 active enable kept", osc_en, 4'b0011);
        wr(2'd0, 5'h02);
        check("R6 other enable cleared", osc_en, 4'b0010);
    endtask

    task automatic t_replace_and_hold();
        logic [4:0] v;
        wr(2'd1, 5'h02);
        rd(2'd1, v); check("R5 first target", v, 5'h19);
        wr(2'd1, 5'h03);
        rd(2'd1, v); check("R5 newer target replaces", v, 5'h1D);
        wait_neg(10);
        check("R8 held while not ready", sys_src, 1);
        rd(2'd1, v); check("R8 still pending", v, 5'h1D);
        wr(2'd1, 5'h01);
        rd(2'd1, v); check("R5 request equal active clears", v, 5'h05);
    endtask

    task automatic t_pll();
        logic [4:0] v;
        wr(2'd0, 5'h1F);
        rdy_raw = 4'b1111;
        wait_neg(4);
        rd(2'd2, v); check("R9 ready status", v, 5'h0F);
        wr(2'd1, 5'h03);
        check("R4 not yet on request edge", sys_src, 1);
        wait_neg(1);
        check("R4 lands next edge", sys_src, 3);
        wr(2'd0, 5'h00);
        check("R7 PLL and its input kept", osc_en, 4'b1100);
        rd(2'd0, v); check("R7 input select frozen", v, 5'h1C);
        wr(2'd1, 5'h00);
        wait_neg(1);
        check("R4 back to multi-speed", sys_src, 0);
        wr(2'd0, 5'h01);
        rd(2'd0, v); check("R7 select writable after PLL", v, 5'h01);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rdy_raw[0] = 1'b1;
        wait_neg(3);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_pending_then_ready();
        t_protect_active();
        t_replace_and_hold();
        t_pll();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule